// File: doc/BRIEF.md
# Packet Data Register With Parity Check

This block is the byte-wide register stage in the datapath of a packet router. A packet reaches it as a header byte, then 1 to 63 payload bytes, then one trailing check byte. Every byte the block accepts is registered on the rising clock edge and presented with a one-cycle valid strobe, ready to be written into an output FIFO. While the packet streams through, the block XORs the header and every payload byte into a running check value. When the trailing byte arrives, the block compares it with that value and raises a packet error flag if they differ.

The sequencing controller is outside the block. It presents three byte-kind strobes (header, payload, check byte) and a stall input that stands for a full downstream FIFO. A small control unit inside the block turns these into accept strobes. It tracks whether a packet is open and resolves cases where several strobes are raised in the same cycle. The datapath unit holds the output register, the check accumulator and the error flag. The header byte carries the payload length in bits 7:2 and the destination address in bits 1:0.

Top module: `pktParityReg`

## Requirements
- R1: While `rstN` is low at a rising clock edge (synchronous, active low), `byteOut` becomes 0x00 and `byteValid`, `pktError` and `checkDone` become 0.
- R2: A header byte accepted at an edge (`isHeader`=1, `stall`=0) appears on `byteOut` after that edge with `byteValid`=1, clears `pktError` and opens a packet.
- R3: A payload byte accepted while a packet is open appears on `byteOut` after the edge with `byteValid`=1.
- R4: While `stall`=1, no byte is accepted: after the edge `byteValid` is 0, and `byteOut`, `pktError` and `checkDone` behave as if no strobe had been raised.
- R5: A check byte accepted while a packet is open appears on `byteOut` with `byteValid`=1 and `checkDone`=1 for exactly one cycle. It closes the packet and sets `pktError` to 1 if and only if it differs from the XOR of the header and all payload bytes of that packet.
- R6: `pktError` keeps its value until the next accepted header or reset.
- R7: A header whose length field (bits 7:2) is zero makes `pktError` rise at that packet's check byte, even when the check byte matches.
- R8: Payload and check-byte strobes while no packet is open are ignored: `byteValid` and `checkDone` stay 0, and `byteOut` and `pktError` keep their values.
- R9: When several strobes are raised together, header wins over check byte, and check byte wins over payload.
- R10: The check accumulator restarts at each accepted header, so a packet's result does not depend on earlier packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| byteIn | input | 8 | Incoming packet byte |
| isHeader | input | 1 | Current byte is a header |
| isPayload | input | 1 | Current byte is payload |
| isCheck | input | 1 | Current byte is the trailing check byte |
| stall | input | 1 | Downstream full; accept nothing this cycle |
| byteOut | output | 8 | Registered byte for the FIFO |
| byteValid | output | 1 | `byteOut` was loaded at the last edge |
| checkDone | output | 1 | Check byte compared at the last edge |
| pktError | output | 1 | Packet failed its check or had zero length |

## Verification
The bench uses the default 8-bit byte with a 2-bit address field, so the header layout and the XOR arithmetic are the ones listed in the requirements. With these values, hand-computed packets are short enough to cover a matching check byte, a wrong check byte, a zero length field, a stalled byte in mid-packet, strobes outside any packet and simultaneous strobes within a few dozen cycles. A reset applied while the error flag is set is then checked on its own.

// File: rtl/pkt_parity_pkg.sv
package pkt_parity_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;
  localparam int LEN_LSB = ADDR_W;
  localparam int LEN_MSB = BYTE_W - 1;

  typedef struct packed {
    logic takeHeader;
    logic takePayload;
    logic takeCheck;
  } acceptStrobes_t;
endpackage

// File: rtl/pkt_parity_ctrl.sv
module pkt_parity_ctrl
  import pkt_parity_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           isHeader,
  input  logic           isPayload,
  input  logic           isCheck,
  input  logic           stall,
  output acceptStrobes_t strobes
);
  logic pktOpen;

  // Priority: header, then check byte, then payload; all gated by stall and packet state.
  always_comb begin
    strobes = '0;
    if (!stall) begin
      if (isHeader)
        strobes.takeHeader = 1'b1;
      else if (isCheck && pktOpen)
        strobes.takeCheck = 1'b1;
      else if (isPayload && pktOpen)
        strobes.takePayload = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      pktOpen <= 1'b0;
    else if (strobes.takeHeader)
      pktOpen <= 1'b1;
    else if (strobes.takeCheck)
      pktOpen <= 1'b0;
  end
endmodule

// File: rtl/pkt_parity_dp.sv
module pkt_parity_dp
  import pkt_parity_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter int LEN_HI = LEN_MSB,
  parameter int LEN_LO = LEN_LSB
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [W-1:0]   byteIn,
  input  acceptStrobes_t strobes,
  output logic [W-1:0]   byteOut,
  output logic           byteValid,
  output logic           checkDone,
  output logic           pktError
);
  localparam int LEN_W = LEN_HI - LEN_LO + 1;

  logic [W-1:0] runParity;
  logic         lenZero;
  logic         anyTake;

  assign anyTake = strobes.takeHeader | strobes.takePayload | strobes.takeCheck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteOut   <= '0;
      byteValid <= 1'b0;
      checkDone <= 1'b0;
      pktError  <= 1'b0;
      runParity <= '0;
      lenZero   <= 1'b0;
    end else begin
      byteValid <= anyTake;
      checkDone <= strobes.takeCheck;
      if (anyTake)
        byteOut <= byteIn;
      if (strobes.takeHeader) begin
        runParity <= byteIn;
        lenZero   <= (byteIn[LEN_HI:LEN_LO] == LEN_W'(0));
        pktError  <= 1'b0;
      end else if (strobes.takePayload) begin
        runParity <= runParity ^ byteIn;
      end else if (strobes.takeCheck) begin
        pktError <= (runParity != byteIn) | lenZero;
      end
    end
  end
endmodule

// File: rtl/pktParityReg.sv
module pktParityReg
  import pkt_parity_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              isHeader,
  input  logic              isPayload,
  input  logic              isCheck,
  input  logic              stall,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteValid,
  output logic              checkDone,
  output logic              pktError
);
  acceptStrobes_t strobes;

  pkt_parity_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .isHeader(isHeader), .isPayload(isPayload), .isCheck(isCheck),
    .stall(stall), .strobes(strobes)
  );

  pkt_parity_dp #(.W(BYTE_W), .LEN_HI(LEN_MSB), .LEN_LO(LEN_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .strobes(strobes),
    .byteOut(byteOut), .byteValid(byteValid),
    .checkDone(checkDone), .pktError(pktError)
  );
endmodule

// File: rtl/pktParityChk.sv
module pktParityChk
  import pkt_parity_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [BYTE_W-1:0] byteIn,
  input logic              isHeader,
  input logic              isPayload,
  input logic              isCheck,
  input logic              stall,
  input logic [BYTE_W-1:0] byteOut,
  input logic              byteValid,
  input logic              checkDone,
  input logic              pktError
);
  a_r2_header_forwarded: assert property (@(posedge clk) disable iff (!rstN)
    (isHeader && !stall) |=> (byteValid && byteOut == $past(byteIn) && !pktError));

  a_r4_stall_blocks: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (!byteValid && !checkDone && $stable(byteOut) && $stable(pktError)));

  a_r6_error_held: assert property (@(posedge clk) disable iff (!rstN)
    (stall || (!isHeader && !isCheck)) |=> $stable(pktError));

  a_r5_done_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    checkDone |-> byteValid);

  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    checkDone |=> !checkDone);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!byteValid && !checkDone && !pktError && byteOut == '0));
endmodule

bind pktParityReg pktParityChk u_chk (
  .clk(clk), .rstN(rstN), .byteIn(byteIn), .isHeader(isHeader),
  .isPayload(isPayload), .isCheck(isCheck), .stall(stall),
  .byteOut(byteOut), .byteValid(byteValid), .checkDone(checkDone),
  .pktError(pktError)
);

// File: tb/test_pktParityReg.sv
`timescale 1ns/1ps
module test_pktParityReg;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] byteIn;
  logic       isHeader, isPayload, isCheck, stall;
  logic [7:0] byteOut;
  logic       byteValid, checkDone, pktError;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pktParityReg i_pktParityReg (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .isHeader(isHeader),
    .isPayload(isPayload), .isCheck(isCheck), .stall(stall),
    .byteOut(byteOut), .byteValid(byteValid), .checkDone(checkDone),
    .pktError(pktError)
  );

  // Row: {hdr,pay,chk,stall, byteIn, expValid, expOut, expErr, expDone}
  localparam int NV = 21;
  localparam logic [22:0] VEC [NV] = '{
    {4'b1000, 8'h0D, 1'b1, 8'h0D, 1'b0, 1'b0},  // R2 header len3 addr1
    {4'b0100, 8'h55, 1'b1, 8'h55, 1'b0, 1'b0},  // R3
    {4'b0101, 8'h77, 1'b0, 8'h55, 1'b0, 1'b0},  // R4 stalled
    {4'b0100, 8'hA0, 1'b1, 8'hA0, 1'b0, 1'b0},  // R3
    {4'b0100, 8'h3C, 1'b1, 8'h3C, 1'b0, 1'b0},  // R3
    {4'b0010, 8'hC4, 1'b1, 8'hC4, 1'b0, 1'b1},  // R5 match
    {4'b0000, 8'h00, 1'b0, 8'hC4, 1'b0, 1'b0},  // R5 done one cycle
    {4'b1000, 8'h06, 1'b1, 8'h06, 1'b0, 1'b0},  // R2
    {4'b0100, 8'h11, 1'b1, 8'h11, 1'b0, 1'b0},  // R3
    {4'b0010, 8'h18, 1'b1, 8'h18, 1'b1, 1'b1},  // R5 mismatch
    {4'b0000, 8'h00, 1'b0, 8'h18, 1'b1, 1'b0},  // R6 held
    {4'b0100, 8'hFF, 1'b0, 8'h18, 1'b1, 1'b0},  // R8 payload outside
    {4'b0010, 8'h00, 1'b0, 8'h18, 1'b1, 1'b0},  // R8 check outside
    {4'b1000, 8'h05, 1'b1, 8'h05, 1'b0, 1'b0},  // R6 cleared by header
    {4'b0100, 8'h05, 1'b1, 8'h05, 1'b0, 1'b0},  // R10
    {4'b0010, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1},  // R10 fresh accumulator
    {4'b1000, 8'h02, 1'b1, 8'h02, 1'b0, 1'b0},  // R7 zero length
    {4'b0100, 8'h09, 1'b1, 8'h09, 1'b0, 1'b0},  // R7
    {4'b0010, 8'h0B, 1'b1, 8'h0B, 1'b1, 1'b1},  // R7 matching but malformed
    {4'b1110, 8'h09, 1'b1, 8'h09, 1'b0, 1'b0},  // R9 header wins
    {4'b0110, 8'h30, 1'b1, 8'h30, 1'b1, 1'b1}   // R9 check wins over payload
  };

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {valid,out,err,done} actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] ctrl, input logic [7:0] d);
    {isHeader, isPayload, isCheck, stall} = ctrl;
    byteIn = d;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    apply(4'b1000, 8'hAA);
    repeat (3) @(negedge clk);
    check("R1 reset state", {byteValid, byteOut, pktError, checkDone}, 11'h000);
    rstN = 1'b1;
    apply(4'b0100, 8'h44);  // payload before any header: R8
    @(negedge clk);
    check("R8 payload before header", {byteValid, byteOut, pktError, checkDone}, 11'h000);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][22:19], VEC[i][18:11]);
      @(negedge clk);
      check($sformatf("R2-vector %0d", i), {byteValid, byteOut, pktError, checkDone}, VEC[i][10:0]);
    end
    // R1: reset while error flag set
    apply(4'b0000, 8'h00);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears error", {byteValid, byteOut, pktError, checkDone}, 11'h000);
    rstN = 1'b1;
    // R4: stalled header must not clear error nor load
    apply(4'b1000, 8'h0D); @(negedge clk);
    apply(4'b0100, 8'h01); @(negedge clk);
    apply(4'b0010, 8'hFF); @(negedge clk);
    check("R5 error set", {byteValid, byteOut, pktError, checkDone}, {1'b1, 8'hFF, 1'b1, 1'b1});
    apply(4'b1001, 8'h21); @(negedge clk);
    check("R4 stalled header ignored", {byteValid, byteOut, pktError, checkDone}, {1'b0, 8'hFF, 1'b1, 1'b0});
    apply(4'b0000, 8'h00); @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule